// File: doc/BRIEF.md
# Supply and Reset Sequencer

This block produces the internal core reset of a small 8051-class microcontroller and records why that reset happened. It watches four sources: an external reset pin, the digital output of a supply-droop comparator, a software reset control bit, and the power-on event, which is also the block's own asynchronous reset. A droop on the supply is either reported as an interrupt request or turned into a reset, depending on an interrupt enable supplied by the core. All asynchronous inputs are synchronized and then filtered digitally against the oscillator clock.

Every reset ends with a stretch of one machine cycle (12 clocks) after its cause has gone. In the last reset cycle the block pulses a request that reloads the program counter with 0000H. During a software reset it drives a mask that names the register bits the core must keep: the software reset bit itself and the watchdog status bit. A sticky power-on flag and a one-hot cause register can be read by software and cleared by it.

The controller has four states. ST_RUN is normal operation. ST_HOLD holds reset while a cause is present. ST_STRETCH counts out the post-cause stretch. ST_BOIRQ raises the droop interrupt. The transitions are:
- T_PIN: from RUN or BOIRQ to HOLD when the filtered pin is high.
- T_BOD: from RUN to HOLD when a filtered droop occurs with the enable clear.
- T_SW: from RUN to HOLD on a rising software bit.
- T_BOIRQ: from RUN to BOIRQ when a filtered droop occurs with the enable set.
- T_BOEND: from BOIRQ to RUN when the droop ends.
- T_BOFORCE: from BOIRQ to HOLD when the enable is cleared while the droop persists.
- T_RELEASE: from HOLD to STRETCH once no cause remains.
- T_RETRIG: from STRETCH back to HOLD when a cause comes back.
- T_DONE: from STRETCH to RUN after 12 clocks.

Top module: `supply_reset_ctrl`

## Requirements
- R1: The external reset pin causes a reset only when its synchronized level stays high for at least 24 consecutive clocks. A pulse of 22 clocks leaves core_rst low.
- R2: The droop input is acted on only after its synchronized level has been high for at least 4 consecutive clocks. A 2-clock assertion changes no output.
- R3: With bo_ie low, a filtered droop asserts core_rst and sets rst_cause to 3'b100.
- R4: With bo_ie high, a filtered droop keeps bo_irq high for as long as the droop lasts and does not assert core_rst. bo_irq falls when the droop ends.
- R5: Clearing bo_ie while a filtered droop is still present asserts core_rst, and rst_cause becomes 3'b100.
- R6: A 0-to-1 change of swr_bit asserts core_rst. Holding swr_bit high does not reset the core again. keep_mask reads 2'b11 during a software reset (bit 0 is the software reset bit, bit 1 the watchdog status bit) and 2'b00 at all other times.
- R7: core_rst stays high for at least 12 clocks after the last cause has gone, and for 12 clocks after por_n is released.
- R8: pc_restart pulses high for exactly one cycle, in the last cycle of each reset, once per reset.
- R9: pof_flag is 1 after power-on and is cleared only by pof_clr. Pin, droop and software resets leave it unchanged.
- R10: rst_cause is one-hot, with bit 0 for the pin, bit 1 for software and bit 2 for a droop. It is 3'b000 after power-on, is overwritten by each new reset, and is cleared by cause_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on event, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| bod_in | input | 1 | Supply-droop comparator output, active high, asynchronous |
| swr_bit | input | 1 | Software reset control bit |
| bo_ie | input | 1 | Droop interrupt enable |
| pof_clr | input | 1 | Software clear of the power-on flag |
| cause_clr | input | 1 | Software clear of the cause register |
| core_rst | output | 1 | Synchronous core reset |
| pc_restart | output | 1 | Reload program counter with 0000H |
| bo_irq | output | 1 | Droop interrupt request (vector 004BH) |
| pof_flag | output | 1 | Sticky power-on flag |
| keep_mask | output | 2 | Register bits that survive the current reset |
| rst_cause | output | 3 | One-hot cause of the last reset |

## Verification
A pin or droop level reaches the state machine 2 synchronizer clocks plus its qualification length after it is driven, and core_rst rises one clock later. A software edge asserts core_rst on the next clock. Once the last cause has gone, the filter takes 3 clocks to clear and core_rst then stays high for 12 more. The bench drives every input on the falling edge and samples on falling edges well inside these windows: it checks that core_rst is still high 10 clocks after a cause is removed, and low again after 30. Pulse lengths are chosen a clear margin away from each threshold.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_HOLD,
        ST_STRETCH,
        ST_BOIRQ
    } rstc_state_e;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_PIN = 0;
    localparam int CAUSE_SW  = 1;
    localparam int CAUSE_BOD = 2;
    localparam int KEEP_W    = 2;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rstc_qual.sv
module rstc_qual #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic qual
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIM = CW'(HOLD);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)            run_cnt <= '0;
        else if (!din)          run_cnt <= '0;
        else if (run_cnt != LIM) run_cnt <= run_cnt + 1'b1;
    end

    assign qual = (run_cnt == LIM);
endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int MC_CLKS     = 12,
    parameter int PIN_MC      = 2,
    parameter int BOD_CLKS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_pin,
    input  logic               bod_in,
    input  logic               swr_bit,
    input  logic               bo_ie,
    input  logic               pof_clr,
    input  logic               cause_clr,
    output logic               core_rst,
    output logic               pc_restart,
    output logic               bo_irq,
    output logic               pof_flag,
    output logic [KEEP_W-1:0]  keep_mask,
    output logic [CAUSE_W-1:0] rst_cause
);
    localparam int PIN_CLKS = PIN_MC * MC_CLKS;
    localparam int SCW      = $clog2(MC_CLKS);
    localparam logic [SCW-1:0] STRETCH_LAST = SCW'(MC_CLKS - 1);

    logic [1:0] raw_in, sync_out;
    logic pin_q, bod_q;

    assign raw_in = {bod_in, rst_pin};

    rstc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .arst_n(por_n), .d(raw_in), .q(sync_out)
    );

    rstc_qual #(.HOLD(PIN_CLKS)) u_pin_qual (
        .clk(clk), .arst_n(por_n), .din(sync_out[0]), .qual(pin_q)
    );

    rstc_qual #(.HOLD(BOD_CLKS)) u_bod_qual (
        .clk(clk), .arst_n(por_n), .din(sync_out[1]), .qual(bod_q)
    );

    rstc_state_e state, state_nx;
    logic [SCW-1:0]     str_cnt;
    logic               swr_prev, sw_kind;
    logic               sw_rise;
    logic               enter_hold;
    logic [CAUSE_W-1:0] enter_cause;

    assign sw_rise = swr_bit & ~swr_prev;

    // Next-state and transition decode
    always_comb begin
        state_nx    = state;
        enter_hold  = 1'b0;
        enter_cause = '0;
        unique case (state)
            ST_RUN: begin
                if (pin_q) begin                       // T_PIN
                    state_nx = ST_HOLD;
                    enter_hold = 1'b1;
                    enter_cause[CAUSE_PIN] = 1'b1;
                end else if (bod_q && !bo_ie) begin    // T_BOD
                    state_nx = ST_HOLD;
                    enter_hold = 1'b1;
                    enter_cause[CAUSE_BOD] = 1'b1;
                end else if (sw_rise) begin            // T_SW
                    state_nx = ST_HOLD;
                    enter_hold = 1'b1;
                    enter_cause[CAUSE_SW] = 1'b1;
                end else if (bod_q) begin              // T_BOIRQ
                    state_nx = ST_BOIRQ;
                end
            end
            ST_BOIRQ: begin
                if (pin_q) begin                       // T_PIN
                    state_nx = ST_HOLD;
                    enter_hold = 1'b1;
                    enter_cause[CAUSE_PIN] = 1'b1;
                end else if (!bod_q) begin             // T_BOEND
                    state_nx = ST_RUN;
                end else if (!bo_ie) begin             // T_BOFORCE
                    state_nx = ST_HOLD;
                    enter_hold = 1'b1;
                    enter_cause[CAUSE_BOD] = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!pin_q && !bod_q) state_nx = ST_STRETCH;   // T_RELEASE
            end
            ST_STRETCH: begin
                if (pin_q || bod_q)              state_nx = ST_HOLD; // T_RETRIG
                else if (str_cnt == STRETCH_LAST) state_nx = ST_RUN;  // T_DONE
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    // State register and retained flags
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state     <= ST_STRETCH;
            str_cnt   <= '0;
            swr_prev  <= 1'b0;
            sw_kind   <= 1'b0;
            pof_flag  <= 1'b1;
            rst_cause <= '0;
        end else begin
            state    <= state_nx;
            swr_prev <= swr_bit;
            if (state_nx == ST_STRETCH && state == ST_STRETCH)
                str_cnt <= str_cnt + 1'b1;
            else
                str_cnt <= '0;
            if (enter_hold) begin
                sw_kind   <= enter_cause[CAUSE_SW];
                rst_cause <= enter_cause;
            end else if (cause_clr) begin
                rst_cause <= '0;
            end
            if (pof_clr) pof_flag <= 1'b0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        core_rst   = 1'b0;
        pc_restart = 1'b0;
        bo_irq     = 1'b0;
        keep_mask  = '0;
        unique case (state)
            ST_RUN:   ;
            ST_BOIRQ: bo_irq = 1'b1;
            ST_HOLD: begin
                core_rst  = 1'b1;
                keep_mask = {KEEP_W{sw_kind}};
            end
            ST_STRETCH: begin
                core_rst   = 1'b1;
                keep_mask  = {KEEP_W{sw_kind}};
                pc_restart = (str_cnt == STRETCH_LAST) && !pin_q && !bod_q;
            end
            default: core_rst = 1'b1;
        endcase
    end
endmodule

// File: rtl/supply_reset_ctrl_chk.sv
module supply_reset_ctrl_chk #(
    parameter int MC_CLKS = 12
) (
    input logic       clk,
    input logic       por_n,
    input logic       core_rst,
    input logic       pc_restart,
    input logic       bo_irq,
    input logic       bo_ie,
    input logic       bod_q,
    input logic       pof_flag,
    input logic       pof_clr,
    input logic [1:0] keep_mask,
    input logic [2:0] rst_cause
);
    logic [7:0] hi_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)             hi_run <= 8'd1;
        else if (!core_rst)     hi_run <= '0;
        else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
    end

    AST_IRQ_WITHOUT_RESET: assert property (@(posedge clk) disable iff (!por_n)
        bo_irq |-> !core_rst);                                      // R4
    AST_FORCED_BY_ENABLE: assert property (@(posedge clk) disable iff (!por_n)
        (bo_irq && !bo_ie && bod_q) |=> core_rst);                  // R5
    AST_KEEP_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (keep_mask != 2'b00) |-> core_rst);                         // R6
    AST_MIN_STRETCH: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_rst) |-> (hi_run >= 8'(MC_CLKS)));               // R7
    AST_RESTART_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        pc_restart |-> core_rst);                                   // R8
    AST_RESTART_LAST: assert property (@(posedge clk) disable iff (!por_n)
        pc_restart |=> !core_rst);                                  // R8
    AST_POF_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (pof_flag && !pof_clr) |=> pof_flag);                       // R9
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(rst_cause));                                       // R10
endmodule

bind supply_reset_ctrl supply_reset_ctrl_chk #(.MC_CLKS(MC_CLKS)) u_chk (
    .clk(clk), .por_n(por_n), .core_rst(core_rst), .pc_restart(pc_restart),
    .bo_irq(bo_irq), .bo_ie(bo_ie), .bod_q(bod_q), .pof_flag(pof_flag),
    .pof_clr(pof_clr), .keep_mask(keep_mask), .rst_cause(rst_cause)
);

// File: tb/supply_reset_ctrl_test.sv
module supply_reset_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic por_n, rst_pin, bod_in, swr_bit, bo_ie, pof_clr, cause_clr;
    logic core_rst, pc_restart, bo_irq, pof_flag;
    logic [1:0] keep_mask;
    logic [2:0] rst_cause;

    int checks = 0;
    int fails  = 0;
    int pc_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_reset_ctrl uut (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .bod_in(bod_in),
        .swr_bit(swr_bit), .bo_ie(bo_ie), .pof_clr(pof_clr), .cause_clr(cause_clr),
        .core_rst(core_rst), .pc_restart(pc_restart), .bo_irq(bo_irq),
        .pof_flag(pof_flag), .keep_mask(keep_mask), .rst_cause(rst_cause)
    );

    always @(negedge clk) if (pc_restart === 1'b1) pc_cnt++;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rst_high_count(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_rst) hi++;
        end
    endtask

    task automatic t_power_on;
        por_n = 1'b0; rst_pin = 0; bod_in = 0; swr_bit = 0; bo_ie = 0;
        pof_clr = 0; cause_clr = 0;
        tick(3);
        por_n = 1'b1;
        pc_cnt = 0;
        tick(10);
        chk("R7 reset held after power-on", core_rst, 1);
        chk("R9 power-on flag set", pof_flag, 1);
        chk("R10 cause clear at power-on", rst_cause, 0);
        tick(4);
        chk("R7 power-on reset released", core_rst, 0);
        chk("R8 one restart after power-on", pc_cnt, 1);
    endtask

    task automatic t_pin_short;
        int hi;
        rst_pin = 1'b1; tick(22); rst_pin = 1'b0;
        rst_high_count(40, hi);
        chk("R1 short pin pulse ignored", hi, 0);
    endtask

    task automatic t_pin_long;
        pc_cnt = 0;
        rst_pin = 1'b1; tick(30);
        chk("R1 long pin pulse resets", core_rst, 1);
        chk("R6 no keep mask on pin reset", keep_mask, 0);
        chk("R10 pin cause", rst_cause, 3'b001);
        rst_pin = 1'b0; tick(10);
        chk("R7 stretch after pin release", core_rst, 1);
        tick(20);
        chk("R7 pin reset ends", core_rst, 0);
        chk("R8 one restart per pin reset", pc_cnt, 1);
        chk("R9 pin reset keeps power-on flag", pof_flag, 1);
    endtask

    task automatic t_bod_short;
        int hi;
        cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
        chk("R10 cause cleared by write", rst_cause, 0);
        bod_in = 1'b1; tick(2); bod_in = 1'b0;
        rst_high_count(20, hi);
        chk("R2 short droop no reset", hi, 0);
        chk("R2 short droop no cause", rst_cause, 0);
    endtask

    task automatic t_bod_reset;
        bo_ie = 1'b0; bod_in = 1'b1; tick(9);
        chk("R3 droop resets", core_rst, 1);
        chk("R3 droop cause", rst_cause, 3'b100);
        bod_in = 1'b0; tick(30);
        chk("R3 droop reset ends", core_rst, 0);
    endtask

    task automatic t_bod_irq;
        int hi;
        bo_ie = 1'b1; bod_in = 1'b1; tick(9);
        chk("R4 droop interrupt raised", bo_irq, 1);
        rst_high_count(10, hi);
        chk("R4 no reset with interrupt", hi, 0);
        bod_in = 1'b0; tick(6);
        chk("R4 interrupt drops", bo_irq, 0);
        chk("R4 no reset after droop", core_rst, 0);
    endtask

    task automatic t_bo_force;
        cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
        bo_ie = 1'b1; bod_in = 1'b1; tick(9);
        chk("R5 interrupt before clear", bo_irq, 1);
        bo_ie = 1'b0; tick(3);
        chk("R5 clearing enable resets", core_rst, 1);
        chk("R5 cause droop", rst_cause, 3'b100);
        bod_in = 1'b0; tick(30);
        chk("R5 reset released", core_rst, 0);
    endtask

    task automatic t_soft;
        int hi;
        pof_clr = 1'b1; tick(1); pof_clr = 1'b0;
        chk("R9 flag cleared by write", pof_flag, 0);
        pc_cnt = 0;
        swr_bit = 1'b1; tick(2);
        chk("R6 software reset", core_rst, 1);
        chk("R6 keep mask", keep_mask, 2'b11);
        chk("R10 software cause", rst_cause, 3'b010);
        tick(20);
        chk("R6 software reset ends", core_rst, 0);
        chk("R6 mask clear after reset", keep_mask, 0);
        rst_high_count(40, hi);
        chk("R6 held bit no retrigger", hi, 0);
        chk("R8 one restart per soft reset", pc_cnt, 1);
        chk("R9 soft reset keeps flag clear", pof_flag, 0);
        swr_bit = 1'b0; tick(2);
    endtask

    initial begin
        t_power_on();
        t_pin_short();
        t_pin_long();
        t_bod_short();
        t_bod_reset();
        t_bod_irq();
        t_bo_force();
        t_soft();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule